// File: doc/BRIEF.md
# Bus Port Halt Handshake Controller

This controller brings one bus master port to a quiet state before its power is removed. A single-cycle command starts the sequence. If the port already reports idle, nothing more is needed and the controller finishes at once without raising its halt request. If the port is busy, the controller raises the halt request and checks the port's acknowledge once every poll interval. It stops waiting when the acknowledge is seen or when the timeout runs out, whichever happens first.

After the wait, the controller looks at the port's idle status once more. If the port is still busy, it records a failure. It always releases the halt request when the sequence ends, whether or not the port halted, because the port is expected to stay halted until it is reset. A one-cycle completion pulse marks the end of each sequence. The failure flag keeps its value until the next accepted command. Both the poll interval and the timeout are parameters counted in clock cycles, so a simulation can use short values while silicon uses about one millisecond and one hundred milliseconds.

Top module: `port_halt_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, halt_req, done and fail are all 0 after that edge.
- R2: A command (halt_cmd high while halt_req is low) that arrives while port_idle is high is completed without a handshake. done is high for the cycle right after the command edge, and halt_req stays 0 throughout.
- R3: A command that arrives while port_idle is low sets halt_req in the next cycle. halt_req then stays high until the cycle in which done is high.
- R4: halt_ack is sampled only at poll edges. These are the edges that fall k*POLL_CYC cycles after the command edge, for k = 1, 2, and so on. If halt_ack is high at poll k, done is high k*POLL_CYC+1 cycles after the command edge. An acknowledge that is high only between poll edges is not seen.
- R5: If halt_ack is low at all TIMEOUT_CYC/POLL_CYC poll edges, the wait ends at the last of them. done is then high TIMEOUT_CYC+1 cycles after the command edge. TIMEOUT_CYC must be a multiple of POLL_CYC.
- R6: When the wait ends, port_idle is sampled once. fail is set to 1 if port_idle was low at that sample, and set to 0 otherwise. The new fail value is visible in the same cycle as done.
- R7: halt_req is 0 in the cycle in which done is high, on the success path and on the failure path alike.
- R8: done lasts exactly one cycle per accepted command. fail keeps its value until the next accepted command, and is 0 in the cycle after that command edge. A command accepted in the same cycle in which done is high counts as a new command.
- R9: halt_cmd is ignored while a handshake is in progress (halt_req high). It changes neither the completion time nor the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| halt_cmd | input | 1 | Start a halt sequence (single-cycle pulse) |
| port_idle | input | 1 | Idle status from the bus port |
| halt_ack | input | 1 | Halt acknowledge from the bus port |
| halt_req | output | 1 | Halt request to the bus port |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| fail | output | 1 | The port was not idle at the final check; held until the next command |

## Verification
Two events can fall on the same clock edge. The first case is a new command that arrives in the very cycle the previous sequence reports done, while fail still holds a 1. The bench provokes it by raising halt_cmd at the sampling point where it first sees done, then checks two things: that a second done follows one cycle later, and that fail has been cleared. The second case is an acknowledge that lands on the last poll edge, which is also the edge where the timeout would fire. The bench places halt_ack exactly there and judges the result by the completion latency and the fail value, comparing it with the case where the acknowledge pulses only between polls and is missed.

// File: rtl/port_halt_pkg.sv
// Shared types for the bus port halt handshake controller.
// Assumes nothing beyond IEEE 1800-2017 packages.
package port_halt_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,  // waiting for a command
        PH_WAIT   = 2'd1,  // request raised, polling for acknowledge
        PH_VERIFY = 2'd2   // final idle check and release
    } ph_state_t;
endpackage

// File: rtl/port_halt_timer.sv
// Poll and timeout timer. While run is high, tick pulses once every POLL_CYC
// cycles, and last_poll marks the tick that completes the timeout window.
// Assumes run is low for at least one cycle between windows (it restarts from zero).
module port_halt_timer #(
    parameter int POLL_CYC    = 100000,
    parameter int TIMEOUT_CYC = 10000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick,
    output logic last_poll
);
    localparam int NPOLLS = (TIMEOUT_CYC / POLL_CYC < 1) ? 1 : TIMEOUT_CYC / POLL_CYC;
    localparam int PW     = (POLL_CYC < 2) ? 1 : $clog2(POLL_CYC);
    localparam int NW     = (NPOLLS < 2) ? 1 : $clog2(NPOLLS);
    localparam logic [PW-1:0] PLAST = PW'(POLL_CYC - 1);
    localparam logic [NW-1:0] NLAST = NW'(NPOLLS - 1);

    logic [PW-1:0] pcnt;
    logic [NW-1:0] ncnt;

    assign tick      = run && (pcnt == PLAST);
    assign last_poll = tick && (ncnt == NLAST);

    // Cycle prescaler: counts clock cycles inside one poll interval.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  pcnt <= '0;
        else if (tick)       pcnt <= '0;
        else                 pcnt <= pcnt + 1'b1;
    end

    // Poll counter: counts poll intervals elapsed in the current window.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  ncnt <= '0;
        else if (tick)       ncnt <= ncnt + 1'b1;
    end
endmodule

// File: rtl/port_halt_fsm.sv
// Sequencer for the halt handshake. It skips the handshake when the port is
// already idle, otherwise it holds the request until an acknowledge poll hits
// or the timeout expires, then checks idle and always releases the request.
// Assumes the tick and last_poll inputs come from port_halt_timer driven by run.
module port_halt_fsm
    import port_halt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halt_cmd,
    input  logic port_idle,
    input  logic halt_ack,
    input  logic tick,
    input  logic last_poll,
    output logic run,
    output logic halt_req,
    output logic done,
    output logic fail
);
    ph_state_t state;

    assign run = (state == PH_WAIT);

    // Main sequence: state, request, completion pulse and failure flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PH_IDLE;
            halt_req <= 1'b0;
            done     <= 1'b0;
            fail     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                PH_IDLE: begin
                    if (halt_cmd) begin
                        fail <= 1'b0;
                        if (port_idle) begin
                            done <= 1'b1;
                        end else begin
                            halt_req <= 1'b1;
                            state    <= PH_WAIT;
                        end
                    end
                end
                PH_WAIT: begin
                    if (tick && (halt_ack || last_poll)) state <= PH_VERIFY;
                end
                PH_VERIFY: begin
                    fail     <= !port_idle;
                    halt_req <= 1'b0;
                    done     <= 1'b1;
                    state    <= PH_IDLE;
                end
                default: state <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/port_halt_ctrl.sv
// Top of the bus port halt handshake controller: wires the poll/timeout timer
// to the sequencer. Both parameters are counted in clock cycles, and
// TIMEOUT_CYC is expected to be a multiple of POLL_CYC.
module port_halt_ctrl #(
    parameter int POLL_CYC    = 100000,
    parameter int TIMEOUT_CYC = 10000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_cmd,
    input  logic port_idle,
    input  logic halt_ack,
    output logic halt_req,
    output logic done,
    output logic fail
);
    logic run;
    logic tick;
    logic last_poll;

    port_halt_timer #(
        .POLL_CYC    (POLL_CYC),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .tick      (tick),
        .last_poll (last_poll)
    );

    port_halt_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt_cmd  (halt_cmd),
        .port_idle (port_idle),
        .halt_ack  (halt_ack),
        .tick      (tick),
        .last_poll (last_poll),
        .run       (run),
        .halt_req  (halt_req),
        .done      (done),
        .fail      (fail)
    );
endmodule

// File: rtl/port_halt_ctrl_chk.sv
// Property checker for port_halt_ctrl, attached with the bind below. It
// observes the ports only and uses a local counter to bound the request window.
module port_halt_ctrl_chk #(
    parameter int POLL_CYC    = 100000,
    parameter int TIMEOUT_CYC = 10000000
) (
    input logic clk,
    input logic rst_n,
    input logic halt_cmd,
    input logic port_idle,
    input logic halt_ack,
    input logic halt_req,
    input logic done,
    input logic fail
);
    localparam int CW = $clog2(TIMEOUT_CYC + 4);
    logic [CW-1:0] req_cycles;

    // Counts consecutive cycles with the request raised.
    always_ff @(posedge clk) begin
        if (!rst_n || !halt_req) req_cycles <= '0;
        else                     req_cycles <= req_cycles + 1'b1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!halt_req && !done && !fail)); // R1
    AST_SKIP_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_cmd && !halt_req && port_idle) |=> (done && !halt_req)); // R2
    AST_START_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_cmd && !halt_req && !port_idle) |=> (halt_req && !done)); // R3
    AST_REQ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> (req_cycles <= CW'(TIMEOUT_CYC + 1))); // R5
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(halt_req) |-> done); // R7
    AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !halt_req); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !halt_cmd) |=> !done); // R8
    AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_cmd && !halt_req) |=> $stable(fail)); // R8
endmodule

bind port_halt_ctrl port_halt_ctrl_chk #(
    .POLL_CYC    (POLL_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt_cmd  (halt_cmd),
    .port_idle (port_idle),
    .halt_ack  (halt_ack),
    .halt_req  (halt_req),
    .done      (done),
    .fail      (fail)
);

// File: tb/sim_port_halt_ctrl.sv
// Directed bench for port_halt_ctrl with a short poll interval and timeout.
module sim_port_halt_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int POLL       = 4;
    localparam int TMO        = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_cmd = 1'b0;
    logic port_idle = 1'b0;
    logic halt_ack = 1'b0;
    logic halt_req, done, fail;
    int   checks = 0;
    int   failures = 0;
    bit   finished = 1'b0;

    port_halt_ctrl #(.POLL_CYC(POLL), .TIMEOUT_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .halt_cmd(halt_cmd), .port_idle(port_idle),
        .halt_ack(halt_ack), .halt_req(halt_req), .done(done), .fail(fail)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Issues a command at the current negedge and follows the sequence to done.
    task automatic run_case(input string tag, input logic idle0, input int ack_on,
                            input int ack_off, input logic idle1, input int busy_cmd,
                            input int exp_lat, input logic exp_fail);
        int lat = -1;
        port_idle = idle0;
        halt_cmd  = 1'b1;
        @(posedge clk); @(negedge clk);
        halt_cmd  = 1'b0;
        port_idle = idle1;
        for (int m = 0; m <= 60; m++) begin
            if (done) begin lat = m; break; end
            if (!halt_req) check({tag, " R3 req held"}, halt_req, 1);
            halt_ack = (m == ack_on) ? 1'b1 : (m == ack_off) ? 1'b0 : halt_ack;
            halt_cmd = (m == busy_cmd);
            @(posedge clk); @(negedge clk);
        end
        halt_cmd = 1'b0;
        halt_ack = 1'b0;
        check({tag, " latency"}, lat, exp_lat);
        check({tag, " R6 fail"}, fail, exp_fail);
        check({tag, " R7 req low at done"}, halt_req, 0);
    endtask

    // R8: done is a single pulse and fail holds its value while nothing happens.
    task automatic hold_case(input logic exp_fail);
        @(posedge clk); @(negedge clk);
        check("R8 done single cycle", done, 0);
        for (int i = 0; i < 5; i++) begin
            @(posedge clk); @(negedge clk);
            check("R8 fail held", fail, exp_fail);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 halt_req reset", halt_req, 0);
        check("R1 done reset", done, 0);
        check("R1 fail reset", fail, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: port already idle, skip the handshake
        run_case("R2 skip", 1'b1, -1, -1, 1'b1, -1, 0, 1'b0);
        hold_case(1'b0);
        // R4: acknowledge at the first and second poll
        run_case("R4 ack poll1", 1'b0, POLL-1, -1, 1'b1, -1, POLL+1, 1'b0);
        run_case("R4 ack poll2", 1'b0, 2*POLL-1, -1, 1'b1, -1, 2*POLL+1, 1'b0);
        // R4: acknowledge only between polls is missed, so the timeout runs
        run_case("R4 ack glitch", 1'b0, 1, 2, 1'b1, -1, TMO+1, 1'b0);
        // R5: no acknowledge, idle at the end
        run_case("R5 timeout idle", 1'b0, -1, -1, 1'b1, -1, TMO+1, 1'b0);
        // R4/R5: acknowledge on the last poll, the same edge as the timeout
        run_case("R4 ack last poll", 1'b0, TMO-1, -1, 1'b1, -1, TMO+1, 1'b0);
        // R6: acknowledge seen but the port is not idle
        run_case("R6 ack not idle", 1'b0, POLL-1, -1, 1'b0, -1, POLL+1, 1'b1);
        hold_case(1'b1);
        // R9: a command while busy is ignored
        run_case("R9 busy cmd", 1'b0, 2*POLL-1, -1, 1'b0, 3, 2*POLL+1, 1'b1);
        // R5/R7: timeout with the port still busy
        run_case("R5 timeout busy", 1'b0, -1, -1, 1'b0, -1, TMO+1, 1'b1);
        // R8: a new command in the done cycle clears fail
        run_case("R8 cmd at done", 1'b1, -1, -1, 1'b1, -1, 0, 1'b0);
        hold_case(1'b0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule